// File: doc/BRIEF.md
# Privileged Trap-Return Unit

This block carries out the two trap-return instructions of a hart that has machine, supervisor and user privilege and may also have the hypervisor extension. The pipeline raises `req_valid` for one cycle, together with the instruction kind (machine return or supervisor return) and a snapshot of the architectural state. That state is the current privilege, the virtualization flag, the machine and hypervisor status words, and both exception PCs. Three static configuration inputs say whether compressed instructions are supported, whether the hypervisor extension is present, and whether any memory-protection rules are configured.

One cycle after a request the unit responds in one of two ways. It can report an exception together with a cause code, and in that case every state output copies the snapshot unchanged. Otherwise it returns the rewritten status words, the privilege and virtualization flag to resume in, and the target PC, marked by `done`. When the return lands in a virtualized context it also pulses a request to swap the hypervisor register banks. The swap is done elsewhere.

Top module: `trap_return_unit`

## Requirements
- R1: Each cycle with `req_valid` high produces, one cycle later, a one-cycle pulse on exactly one of `done` or `exc_valid`. Neither output pulses in any other cycle.
- R2: Privilege is encoded as user=0, supervisor=1, machine=3. A machine return below machine privilege, or a supervisor return at user privilege, raises cause 2 (illegal instruction). This check has the highest priority.
- R3: When `cfg_rvc` is 0 and the selected return PC has either of bits [1:0] set, the unit raises cause 0 (misaligned target). This check ranks second.
- R4: A supervisor return below machine privilege, with mstatus bit 22 (trap-sret) set, raises cause 2. This check ranks third.
- R5: A supervisor return with `cfg_hyp`=1, `cur_virt`=1 and hstatus bit 22 set raises cause 22 (virtual instruction). This check ranks last.
- R6: A machine return with `cfg_pmp`=0 raises cause 2 when the old mstatus[12:11] is not 3. This check ranks after R3.
- R7: A machine return makes mstatus bit 3 equal the old bit 7, sets bit 7, and clears bits [12:11] and bit 39. The new privilege is the old mstatus[12:11]. All other bits stay unchanged.
- R8: On a machine return with `cfg_hyp`=1, `virt_o` takes the old mstatus bit 39, and `swap_req` pulses when that bit is 1. With `cfg_hyp`=0, `virt_o` equals `cur_virt` and no swap is requested.
- R9: A supervisor return with `cfg_hyp`=1 and `cur_virt`=0 clears hstatus bit 7 and sets `virt_o` to the old hstatus bit 7, pulsing `swap_req` when that bit is 1.
- R10: Every supervisor return makes mstatus bit 1 equal the old bit 5, sets bit 5, and clears bit 8. The new privilege is the old bit 8 (0 or 1). Outside the R9 case, hstatus and the virtualization flag stay unchanged and no swap is requested.
- R11: On an exception, `mstatus_o`, `hstatus_o`, `priv_o` and `virt_o` equal the request's inputs, and `swap_req` stays 0.
- R12: With `done`, `ret_pc` equals `mepc_i` for a machine return and `sepc_i` for a supervisor return.
- R13: After reset, `done`, `exc_valid` and `swap_req` are 0, `priv_o` is 3, and `virt_o`, `mstatus_o`, `hstatus_o` and `ret_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Return request, one cycle |
| req_is_sret | input | 1 | 1 = supervisor return, 0 = machine return |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization flag |
| mstatus_i | input | 64 | Machine status word |
| hstatus_i | input | 64 | Hypervisor status word |
| mepc_i | input | 64 | Machine exception PC |
| sepc_i | input | 64 | Supervisor exception PC |
| cfg_rvc | input | 1 | Compressed instructions supported |
| cfg_hyp | input | 1 | Hypervisor extension present |
| cfg_pmp | input | 1 | At least one protection rule configured |
| done | output | 1 | Successful return strobe |
| exc_valid | output | 1 | Exception strobe |
| exc_cause | output | 5 | Exception cause code |
| mstatus_o | output | 64 | Updated machine status |
| hstatus_o | output | 64 | Updated hypervisor status |
| priv_o | output | 2 | Privilege after return |
| virt_o | output | 1 | Virtualization flag after return |
| ret_pc | output | 64 | Return target PC |
| swap_req | output | 1 | Hypervisor register bank swap request |

## Verification
The hardest cases to reach are the ones where several exception conditions are true at once, because only the priority order decides which cause is reported. The stimulus therefore builds snapshots that pair conditions on purpose. These include a machine return that is both below machine privilege and misaligned, and a supervisor return that is misaligned with trap-sret set. Another sets trap-sret and virtual trap-sret together, and a further case sets virtual trap-sret in virtual mode with the hypervisor path disabled. Each pairing is repeated with the stronger condition removed, so the next cause in the order shows through.

// File: rtl/trapret_pkg.sv
package trapret_pkg;
    localparam int XLEN = 64;
    localparam int CW   = 5;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // mstatus field positions
    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPPL = 11;
    localparam int B_TSR  = 22;
    localparam int B_MPV  = 39;
    // hstatus field positions
    localparam int B_SPV  = 7;
    localparam int B_VTSR = 22;

    localparam logic [CW-1:0] CAUSE_MISALIGN = 5'd0;
    localparam logic [CW-1:0] CAUSE_ILLEGAL  = 5'd2;
    localparam logic [CW-1:0] CAUSE_VIRT     = 5'd22;

    typedef struct packed {
        logic            done;
        logic            exc;
        logic [CW-1:0]   cause;
        logic [XLEN-1:0] mst;
        logic [XLEN-1:0] hst;
        logic [1:0]      priv;
        logic            virt;
        logic [XLEN-1:0] pc;
        logic            swap;
    } ret_state_t;
endpackage

// File: rtl/trapret_check.sv
module trapret_check
    import trapret_pkg::*;
(
    input  logic            is_sret,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic [XLEN-1:0] mst,
    input  logic [XLEN-1:0] hst,
    input  logic [1:0]      tgt_low,
    input  logic            cfg_rvc,
    input  logic            cfg_hyp,
    input  logic            cfg_pmp,
    output logic            fault,
    output logic [CW-1:0]   cause
);
    logic priv_bad_d, misal_d, gate_d, tsr_d, vtsr_d;

    always_comb begin
        priv_bad_d = is_sret ? (cur_priv == PRIV_U) : (cur_priv != PRIV_M);
        misal_d    = !cfg_rvc && (tgt_low != 2'b00);
        gate_d     = !is_sret && !cfg_pmp && (mst[B_MPPL+1:B_MPPL] != PRIV_M);
        tsr_d      = is_sret && mst[B_TSR] && (cur_priv != PRIV_M);
        vtsr_d     = is_sret && cfg_hyp && cur_virt && hst[B_VTSR];

        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
        if (priv_bad_d)   cause = CAUSE_ILLEGAL;
        else if (misal_d) cause = CAUSE_MISALIGN;
        else if (gate_d)  cause = CAUSE_ILLEGAL;
        else if (tsr_d)   cause = CAUSE_ILLEGAL;
        else if (vtsr_d)  cause = CAUSE_VIRT;
        else              fault = 1'b0;
    end
endmodule

// File: rtl/trapret_update.sv
module trapret_update
    import trapret_pkg::*;
(
    input  logic            is_sret,
    input  logic            cur_virt,
    input  logic [XLEN-1:0] mst,
    input  logic [XLEN-1:0] hst,
    input  logic            cfg_hyp,
    output logic [XLEN-1:0] mst_d,
    output logic [XLEN-1:0] hst_d,
    output logic [1:0]      priv_d,
    output logic            virt_d,
    output logic            swap_d
);
    always_comb begin
        mst_d  = mst;
        hst_d  = hst;
        virt_d = cur_virt;
        swap_d = 1'b0;
        if (!is_sret) begin
            mst_d[B_MIE]              = mst[B_MPIE];
            mst_d[B_MPIE]             = 1'b1;
            mst_d[B_MPPL+1:B_MPPL]    = PRIV_U;
            mst_d[B_MPV]              = 1'b0;
            priv_d                    = mst[B_MPPL+1:B_MPPL];
            if (cfg_hyp) begin
                virt_d = mst[B_MPV];
                swap_d = mst[B_MPV];
            end
        end else begin
            mst_d[B_SIE]  = mst[B_SPIE];
            mst_d[B_SPIE] = 1'b1;
            mst_d[B_SPP]  = 1'b0;
            priv_d        = {1'b0, mst[B_SPP]};
            if (cfg_hyp && !cur_virt) begin
                hst_d[B_SPV] = 1'b0;
                virt_d       = hst[B_SPV];
                swap_d       = hst[B_SPV];
            end
        end
    end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trapret_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_is_sret,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic [63:0]     mstatus_i,
    input  logic [63:0]     hstatus_i,
    input  logic [63:0]     mepc_i,
    input  logic [63:0]     sepc_i,
    input  logic            cfg_rvc,
    input  logic            cfg_hyp,
    input  logic            cfg_pmp,
    output logic            done,
    output logic            exc_valid,
    output logic [4:0]      exc_cause,
    output logic [63:0]     mstatus_o,
    output logic [63:0]     hstatus_o,
    output logic [1:0]      priv_o,
    output logic            virt_o,
    output logic [63:0]     ret_pc,
    output logic            swap_req
);
    ret_state_t      st_d, st_q;
    logic [XLEN-1:0] tgt_pc;
    logic            fault;
    logic [CW-1:0]   cause;
    logic [XLEN-1:0] upd_mst, upd_hst;
    logic [1:0]      upd_priv;
    logic            upd_virt, upd_swap;

    assign tgt_pc = req_is_sret ? sepc_i : mepc_i;

    trapret_check u_check (
        .is_sret (req_is_sret),
        .cur_priv(cur_priv),
        .cur_virt(cur_virt),
        .mst     (mstatus_i),
        .hst     (hstatus_i),
        .tgt_low (tgt_pc[1:0]),
        .cfg_rvc (cfg_rvc),
        .cfg_hyp (cfg_hyp),
        .cfg_pmp (cfg_pmp),
        .fault   (fault),
        .cause   (cause)
    );

    trapret_update u_update (
        .is_sret (req_is_sret),
        .cur_virt(cur_virt),
        .mst     (mstatus_i),
        .hst     (hstatus_i),
        .cfg_hyp (cfg_hyp),
        .mst_d   (upd_mst),
        .hst_d   (upd_hst),
        .priv_d  (upd_priv),
        .virt_d  (upd_virt),
        .swap_d  (upd_swap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.exc  = 1'b0;
        st_d.swap = 1'b0;
        if (req_valid) begin
            st_d.pc = tgt_pc;
            if (fault) begin
                st_d.exc   = 1'b1;
                st_d.cause = cause;
                st_d.mst   = mstatus_i;
                st_d.hst   = hstatus_i;
                st_d.priv  = cur_priv;
                st_d.virt  = cur_virt;
            end else begin
                st_d.done  = 1'b1;
                st_d.mst   = upd_mst;
                st_d.hst   = upd_hst;
                st_d.priv  = upd_priv;
                st_d.virt  = upd_virt;
                st_d.swap  = upd_swap;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.done;
    assign exc_valid = st_q.exc;
    assign exc_cause = st_q.cause;
    assign mstatus_o = st_q.mst;
    assign hstatus_o = st_q.hst;
    assign priv_o    = st_q.priv;
    assign virt_o    = st_q.virt;
    assign ret_pc    = st_q.pc;
    assign swap_req  = st_q.swap;

    p_one_response_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (done ^ exc_valid));
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && !exc_valid));
    p_exc_keeps_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid ##1 exc_valid |-> (mstatus_o == $past(mstatus_i)) &&
            (priv_o == $past(cur_priv)) && (virt_o == $past(cur_virt)) && !swap_req);
    p_swap_enters_virt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req |-> (done && virt_o));
    p_mret_clears_prev_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_is_sret ##1 done |->
            (mstatus_o[B_MPPL+1:B_MPPL] == PRIV_U) && !mstatus_o[B_MPV] && mstatus_o[B_MPIE]);
    p_misalign_needs_norvc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid ##1 (exc_valid && exc_cause == CAUSE_MISALIGN) |-> !$past(cfg_rvc));
    p_target_pc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid ##1 done |-> ret_pc == ($past(req_is_sret) ? $past(sepc_i) : $past(mepc_i)));
endmodule

// File: tb/trap_return_unit_bench.sv
`timescale 1ns/1ps
module trap_return_unit_bench;
    typedef struct packed {
        logic        done;
        logic        exc;
        logic [4:0]  cause;
        logic [63:0] mst;
        logic [63:0] hst;
        logic [1:0]  priv;
        logic        virt;
        logic [63:0] pc;
        logic        swap;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_sret = 1'b0;
    logic [1:0] cur_priv = 2'd3;
    logic cur_virt = 1'b0;
    logic [63:0] mstatus_i = '0, hstatus_i = '0, mepc_i = '0, sepc_i = '0;
    logic cfg_rvc = 1'b1, cfg_hyp = 1'b0, cfg_pmp = 1'b1;
    logic done, exc_valid, virt_o, swap_req;
    logic [4:0] exc_cause;
    logic [63:0] mstatus_o, hstatus_o, ret_pc;
    logic [1:0] priv_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    item_t exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    trap_return_unit u_trap_return_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_sret(req_is_sret),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .mstatus_i(mstatus_i),
        .hstatus_i(hstatus_i), .mepc_i(mepc_i), .sepc_i(sepc_i), .cfg_rvc(cfg_rvc),
        .cfg_hyp(cfg_hyp), .cfg_pmp(cfg_pmp), .done(done), .exc_valid(exc_valid),
        .exc_cause(exc_cause), .mstatus_o(mstatus_o), .hstatus_o(hstatus_o),
        .priv_o(priv_o), .virt_o(virt_o), .ret_pc(ret_pc), .swap_req(swap_req)
    );

    function automatic item_t model(input logic s, input logic [1:0] p, input logic v,
                                    input logic [63:0] ms, input logic [63:0] hs,
                                    input logic [63:0] me, input logic [63:0] se,
                                    input logic rvc, input logic hyp, input logic pmp);
        item_t e;
        logic [63:0] tgt;
        e = '0;
        tgt = s ? se : me;
        e.pc = tgt;
        e.exc = 1'b1;
        if (!s && p != 2'd3)                  e.cause = 5'd2;   // R2
        else if (s && p == 2'd0)              e.cause = 5'd2;   // R2
        else if (!rvc && tgt[1:0] != 2'b00)   e.cause = 5'd0;   // R3
        else if (!s && !pmp && ms[12:11] != 2'd3) e.cause = 5'd2; // R6
        else if (s && ms[22] && p != 2'd3)    e.cause = 5'd2;   // R4
        else if (s && hyp && v && hs[22])     e.cause = 5'd22;  // R5
        else                                  e.exc = 1'b0;
        if (e.exc) begin                                        // R11
            e.mst = ms; e.hst = hs; e.priv = p; e.virt = v;
        end else begin
            e.done = 1'b1;
            e.mst = ms; e.hst = hs; e.virt = v;
            if (!s) begin                                       // R7, R8
                e.mst[3] = ms[7]; e.mst[7] = 1'b1; e.mst[12:11] = 2'd0; e.mst[39] = 1'b0;
                e.priv = ms[12:11];
                if (hyp) begin e.virt = ms[39]; e.swap = ms[39]; end
            end else begin                                      // R9, R10
                e.mst[1] = ms[5]; e.mst[5] = 1'b1; e.mst[8] = 1'b0;
                e.priv = {1'b0, ms[8]};
                if (hyp && !v) begin e.hst[7] = 1'b0; e.virt = hs[7]; e.swap = hs[7]; end
            end
        end
        return e;
    endfunction

    task automatic drive(input string tag, input logic s, input logic [1:0] p, input logic v,
                         input logic [63:0] ms, input logic [63:0] hs,
                         input logic [63:0] me, input logic [63:0] se,
                         input logic rvc, input logic hyp, input logic pmp);
        @(negedge clk);
        req_valid = 1'b1; req_is_sret = s; cur_priv = p; cur_virt = v;
        mstatus_i = ms; hstatus_i = hs; mepc_i = me; sepc_i = se;
        cfg_rvc = rvc; cfg_hyp = hyp; cfg_pmp = pmp;
        exp_q.push_back(model(s, p, v, ms, hs, me, se, rvc, hyp, pmp));
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && (done || exc_valid)) begin
            item_t a, e;
            string t;
            a = '{done, exc_valid, exc_cause, mstatus_o, hstatus_o, priv_o, virt_o, ret_pc, swap_req};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1 unrequested response actual=%h expected=none", a);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e.exc) begin a.pc = '0; e.pc = '0; end
                if (!e.exc && e.cause == 5'd0) a.cause = '0;
                if (!e.exc) a.cause = '0;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R13 reset state
        if (done !== 1'b0 || exc_valid !== 1'b0 || swap_req !== 1'b0 || priv_o !== 2'd3 ||
            virt_o !== 1'b0 || mstatus_o !== 64'h0 || hstatus_o !== 64'h0 || ret_pc !== 64'h0) begin
            errors++;
            $display("FAIL R13 reset actual=%b%b%b%h%b expected=00030", done, exc_valid, swap_req, priv_o, virt_o);
        end
        rst_n = 1'b1;
        // R7 machine return to S, other bits preserved
        drive("R7", 0, 2'd3, 0, 64'hA000_0000_0000_0880, 64'h0, 64'h1000, 64'h2000, 1, 0, 1);
        // R7 MPIE=0, MIE=1 goes to 0, return to U
        drive("R7", 0, 2'd3, 0, 64'h0000_0000_0000_0008, 64'h0, 64'h1004, 64'h2000, 1, 0, 1);
        // R8 hyp present, MPV=1 -> virt and swap
        drive("R8", 0, 2'd3, 0, 64'h0000_0080_0000_0880, 64'h0, 64'h1008, 64'h0, 1, 1, 1);
        // R8 no hyp, MPV=1 -> virt unchanged, no swap
        drive("R8", 0, 2'd3, 1, 64'h0000_0080_0000_0800, 64'h0, 64'h100C, 64'h0, 1, 0, 1);
        // R2 privilege
        drive("R2", 0, 2'd1, 0, 64'h0000_0000_0000_1880, 64'h0, 64'h1000, 64'h0, 1, 0, 1);
        drive("R2", 1, 2'd0, 0, 64'h0000_0000_0000_0120, 64'h0, 64'h0, 64'h3000, 1, 0, 1);
        // R2 ranks above R3
        drive("R2", 0, 2'd0, 0, 64'h0, 64'h0, 64'h1002, 64'h0, 0, 0, 1);
        // R3 misaligned without compressed support, and accepted with it
        drive("R3", 0, 2'd3, 0, 64'h0000_0000_0000_1800, 64'h0, 64'h1002, 64'h0, 0, 0, 1);
        drive("R3", 0, 2'd3, 0, 64'h0000_0000_0000_1800, 64'h0, 64'h1002, 64'h0, 1, 0, 1);
        // R3 ranks above R4
        drive("R3", 1, 2'd1, 0, 64'h0000_0000_0040_0000, 64'h0, 64'h0, 64'h3001, 0, 0, 1);
        // R6 no protection rules
        drive("R6", 0, 2'd3, 0, 64'h0000_0000_0000_0800, 64'h0, 64'h1000, 64'h0, 1, 0, 0);
        drive("R6", 0, 2'd3, 0, 64'h0000_0000_0000_1880, 64'h0, 64'h1010, 64'h0, 1, 0, 0);
        // R4 trap-sret
        drive("R4", 1, 2'd1, 0, 64'h0000_0000_0040_0020, 64'h0, 64'h0, 64'h3000, 1, 0, 1);
        drive("R4", 1, 2'd3, 0, 64'h0000_0000_0040_0120, 64'h0, 64'h0, 64'h3004, 1, 0, 1);
        // R5 virtual trap-sret
        drive("R5", 1, 2'd1, 1, 64'h0000_0000_0000_0020, 64'h0000_0000_0040_0000, 64'h0, 64'h3008, 1, 1, 1);
        drive("R5", 1, 2'd1, 1, 64'h0000_0000_0040_0020, 64'h0000_0000_0040_0000, 64'h0, 64'h3008, 1, 1, 1);
        drive("R5", 1, 2'd1, 1, 64'h0000_0000_0000_0020, 64'h0000_0000_0040_0000, 64'h0, 64'h3008, 1, 0, 1);
        // R9 hyp path, SPV=1 SPP=1 SPIE=1
        drive("R9", 1, 2'd1, 0, 64'h0000_0000_0000_0120, 64'h0000_0000_0000_0081, 64'h0, 64'h300C, 1, 1, 1);
        drive("R9", 1, 2'd3, 0, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0000, 64'h0, 64'h3010, 1, 1, 1);
        // R10 plain path
        drive("R10", 1, 2'd1, 0, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0080, 64'h0, 64'h3014, 1, 0, 1);
        drive("R10", 1, 2'd1, 1, 64'h0000_0000_0000_0120, 64'h0000_0000_0000_0080, 64'h0, 64'h3018, 1, 1, 1);
        // R11 exception keeps state, with non-trivial status words
        drive("R11", 1, 2'd1, 1, 64'hFFFF_0000_0040_0000, 64'h0000_0000_0040_00FF, 64'h0, 64'h301C, 1, 1, 1);
        // R12 target selection with distinct PCs
        drive("R12", 1, 2'd3, 0, 64'h0, 64'h0, 64'hAAAA_0000, 64'h5555_0000, 1, 0, 1);
        drive("R12", 0, 2'd3, 0, 64'h1800, 64'h0, 64'hAAAA_0000, 64'h5555_0000, 1, 0, 1);
        // R1 back-to-back then idle: no pending or stray responses
        repeat (6) @(negedge clk);
        checks++;
        if (exp_q.size() != 0 || done || exc_valid) begin
            errors++;
            $display("FAIL R1 pending actual=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule